// File: doc/BRIEF.md
# Host-Alive Watchdog with Fault Latch

This block sits inside a peripheral and checks that the host controller driving it is still running. The host arms it by writing an enable bit, together with a two-bit interval code, into the configuration register at address 0x9. After that the host has to keep the timer from running out by reading the status address 0x1. The internal decoder of the peripheral presents each of those accesses as a one-cycle request on a simple register port. Reads of 0x1 are the only thing that restarts the count.

If a full interval goes by without such a read, the block latches a fault. From the same cycle it requests a safe state for the output drivers, holds its active-low fault pin asserted and pulls the power-good output low for a fixed 56 µs window. It also drops its own enable and raises a sticky flag at bit 9 of register 0x3. The latch stays set until the host sends a clear-faults strobe or a gate-enable reset strobe. The watchdog does not run again until software writes the enable bit once more. The interval lengths and the pulse width are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `host_watchdog`

## Requirements
- R1: After reset fault_n is 1, pgood is 1, safe_state is 0, and reads of 0x9 and 0x3 return 0.
- R2: A write to address 0x9 sets the enable from data bit 3 and the interval code from data bits 6:5. A read of 0x9 returns those bits in the same positions and zero elsewhere. While the enable is 0 the timer never expires.
- R3: While the watchdog is enabled, a read of address 0x1 restarts the count. Expiry then comes L cycles after the accept edge of the last such read, where L is the selected interval.
- R4: With no restart, expiry comes L cycles after the accept edge of the enabling write. From that edge on fault_n is 0 and safe_state is 1, and both keep these values while the latch is set.
- R5: pgood goes low at the expiry edge and stays low for exactly PULSE_US microseconds, counted in clock cycles. It then returns to 1.
- R6: Expiry clears the enable bit, so bit 3 of register 0x9 reads 0 afterwards. The interval code is left as it was.
- R7: Bit 9 of a read of 0x3 is the fault flag. It stays set until cleared. After the flag is cleared, no new fault occurs unless the enable is written again.
- R8: A one-cycle clr_faults or gate_reset strobe clears the latch, so fault_n returns to 1, safe_state to 0 and the flag to 0. An expiry in the same cycle as the strobe takes priority and leaves the fault set.
- R9: Reads of addresses other than 0x1, writes to any address, and a write to 0x1 do not restart the timer.
- R10: A read of 0x1 accepted on the very edge where expiry would occur counts as a restart and prevents the fault.
- R11: Only a change of the enable from 0 to 1 starts a fresh count. Writing 1 again while the watchdog is enabled does not restart it.
- R12: Interval codes 0, 1, 2 and 3 select INTV0_US, INTV1_US, INTV2_US and INTV3_US microseconds. Each is converted to cycles as CLK_HZ times the value divided by 10^6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | One-cycle register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the presented address (combinational) |
| clr_faults | input | 1 | Clear-faults strobe |
| gate_reset | input | 1 | Gate-enable reset strobe, clears the latch |
| safe_state | output | 1 | Request to force the output drivers safe |
| fault_n | output | 1 | Active-low fault indicator |
| pgood | output | 1 | Power-good output, pulsed low on expiry |

## Verification
The timer is first left to run out with no restart, which fixes the expiry edge and the exact length of the power-good pulse. Next it is restarted at regular intervals with decoy traffic in between: status reads, writes elsewhere and a write to the restart address. This shows that only a real read of 0x1 restarts the count. Two single-cycle races are tried, a restart read and a clear strobe each landing on the expiry edge, and they show which event wins. A long-interval run that rewrites the enable midway, and a disabled run, separate the 0-to-1 arming from a plain rewrite and confirm that a disabled timer stays quiet.

// File: rtl/hwd_pkg.sv
package hwd_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] ADDR_KICK   = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'h3;
    localparam logic [ADDR_W-1:0] ADDR_CFG    = 4'h9;

    localparam int CFG_EN_BIT   = 3;
    localparam int CFG_SEL_LSB  = 5;
    localparam int STAT_WDF_BIT = 9;

    typedef struct packed {
        logic       en;
        logic [1:0] sel;
    } cfg_t;

    function automatic longint unsigned us_to_cycles(longint unsigned hz,
                                                     longint unsigned us);
        longint unsigned c;
        c = (hz * us) / 64'd1000000;
        if (c == 0) c = 1;
        return c;
    endfunction
endpackage

// File: rtl/hwd_regs.sv
module hwd_regs
    import hwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              expire,
    input  logic              fault,
    output cfg_t              cfg,
    output logic              kick,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        cfg_t cfg;
    } st_t;

    st_t  cur_q, nxt_d;
    logic cfg_wr;

    always_comb begin
        nxt_d  = cur_q;
        cfg_wr = bus_valid && bus_write && (bus_addr == ADDR_CFG);
        kick   = bus_valid && !bus_write && (bus_addr == ADDR_KICK);
        if (cfg_wr) begin
            nxt_d.cfg.en  = bus_wdata[CFG_EN_BIT];
            nxt_d.cfg.sel = bus_wdata[CFG_SEL_LSB +: 2];
        end
        // an expiry always drops the enable, even against a same-cycle write
        if (expire) begin
            nxt_d.cfg.en = 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (bus_addr)
            ADDR_CFG: begin
                rdata[CFG_EN_BIT]         = cur_q.cfg.en;
                rdata[CFG_SEL_LSB +: 2]   = cur_q.cfg.sel;
            end
            ADDR_STATUS: rdata[STAT_WDF_BIT] = fault;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cfg = cur_q.cfg;
endmodule

// File: rtl/hwd_timer.sv
module hwd_timer #(
    parameter int unsigned LIM0 = 10,
    parameter int unsigned LIM1 = 20,
    parameter int unsigned LIM2 = 50,
    parameter int unsigned LIM3 = 100,
    localparam int unsigned LMAX01 = (LIM0 > LIM1) ? LIM0 : LIM1,
    localparam int unsigned LMAX23 = (LIM2 > LIM3) ? LIM2 : LIM3,
    localparam int unsigned LMAX   = (LMAX01 > LMAX23) ? LMAX01 : LMAX23,
    localparam int          CNT_W  = $clog2(LMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       sel,
    input  logic             kick,
    output logic             expire,
    output logic [CNT_W-1:0] count
);
    localparam int unsigned LIMS [4] = '{LIM0, LIM1, LIM2, LIM3};

    logic [CNT_W-1:0] top_val [4];

    for (genvar g = 0; g < 4; g++) begin : g_top
        assign top_val[g] = CNT_W'(LIMS[g] - 1);
    end

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        expire = 1'b0;
        if (!en) begin
            nxt_d.cnt = '0;              // disabled: held at zero, so arming starts fresh
        end else if (kick) begin
            nxt_d.cnt = '0;              // restart wins over a same-cycle expiry
        end else if (cur_q.cnt >= top_val[sel]) begin
            expire    = 1'b1;
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign count = cur_q.cnt;
endmodule

// File: rtl/hwd_fault.sv
module hwd_fault #(
    parameter  int unsigned PULSE_CYC = 56,
    localparam int          PCNT_W    = $clog2(PULSE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic              clr_faults,
    input  logic              gate_reset,
    output logic              fault,
    output logic              pgood,
    output logic [PCNT_W-1:0] pulse_cnt
);
    typedef struct packed {
        logic              fault;
        logic [PCNT_W-1:0] pcnt;
    } st_t;

    st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (expire) begin
            nxt_d.fault = 1'b1;
        end else if (clr_faults || gate_reset) begin
            nxt_d.fault = 1'b0;
        end

        if (expire) begin
            nxt_d.pcnt = PCNT_W'(PULSE_CYC);
        end else if (cur_q.pcnt != '0) begin
            nxt_d.pcnt = cur_q.pcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign fault     = cur_q.fault;
    assign pulse_cnt = cur_q.pcnt;
    assign pgood     = (cur_q.pcnt == '0);
endmodule

// File: rtl/host_watchdog.sv
module host_watchdog
    import hwd_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 250_000_000,
    parameter longint unsigned INTV0_US = 10_000,
    parameter longint unsigned INTV1_US = 20_000,
    parameter longint unsigned INTV2_US = 50_000,
    parameter longint unsigned INTV3_US = 100_000,
    parameter longint unsigned PULSE_US = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              clr_faults,
    input  logic              gate_reset,
    output logic              safe_state,
    output logic              fault_n,
    output logic              pgood
);
    localparam int unsigned LIM0      = int'(us_to_cycles(CLK_HZ, INTV0_US));
    localparam int unsigned LIM1      = int'(us_to_cycles(CLK_HZ, INTV1_US));
    localparam int unsigned LIM2      = int'(us_to_cycles(CLK_HZ, INTV2_US));
    localparam int unsigned LIM3      = int'(us_to_cycles(CLK_HZ, INTV3_US));
    localparam int unsigned PULSE_CYC = int'(us_to_cycles(CLK_HZ, PULSE_US));
    localparam int          PCNT_W    = $clog2(PULSE_CYC + 1);
    localparam int unsigned LMAX01    = (LIM0 > LIM1) ? LIM0 : LIM1;
    localparam int unsigned LMAX23    = (LIM2 > LIM3) ? LIM2 : LIM3;
    localparam int unsigned LMAX      = (LMAX01 > LMAX23) ? LMAX01 : LMAX23;
    localparam int          CNT_W     = $clog2(LMAX + 1);

    cfg_t              cfg;
    logic              kick;
    logic              expire;
    logic              fault;
    logic [CNT_W-1:0]  count;
    logic [PCNT_W-1:0] pulse_cnt;

    hwd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .expire    (expire),
        .fault     (fault),
        .cfg       (cfg),
        .kick      (kick),
        .rdata     (bus_rdata)
    );

    hwd_timer #(
        .LIM0 (LIM0),
        .LIM1 (LIM1),
        .LIM2 (LIM2),
        .LIM3 (LIM3)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg.en),
        .sel    (cfg.sel),
        .kick   (kick),
        .expire (expire),
        .count  (count)
    );

    hwd_fault #(
        .PULSE_CYC (PULSE_CYC)
    ) u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .clr_faults (clr_faults),
        .gate_reset (gate_reset),
        .fault      (fault),
        .pgood      (pgood),
        .pulse_cnt  (pulse_cnt)
    );

    assign safe_state = fault;
    assign fault_n    = ~fault;
endmodule

// File: rtl/host_watchdog_chk.sv
module host_watchdog_chk #(
    parameter int unsigned PULSE_CYC = 56,
    parameter int          PCNT_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fault_n,
    input logic              safe_state,
    input logic              pgood,
    input logic              en,
    input logic              kick,
    input logic              expire,
    input logic              clr_faults,
    input logic              gate_reset,
    input logic [PCNT_W-1:0] pulse_cnt
);
    a_r5_pulse_starts_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> !pgood);

    a_r5_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= PCNT_W'(PULSE_CYC));

    a_r6_enable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !en);

    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !$fell(fault_n));

    a_r10_kick_blocks_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (en && kick) |=> !$fell(fault_n));

    a_r8_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_faults || gate_reset) && !expire) |=> fault_n);

    a_r4_safe_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> safe_state);
endmodule

bind host_watchdog host_watchdog_chk #(
    .PULSE_CYC (PULSE_CYC),
    .PCNT_W    (PCNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_n    (fault_n),
    .safe_state (safe_state),
    .pgood      (pgood),
    .en         (cfg.en),
    .kick       (kick),
    .expire     (expire),
    .clr_faults (clr_faults),
    .gate_reset (gate_reset),
    .pulse_cnt  (pulse_cnt)
);

// File: tb/host_watchdog_bench.sv
module host_watchdog_bench;
    localparam int L0 = 40, L1 = 80, L3 = 320, P = 56;
    localparam int S_FN = 0, S_PG = 1, S_SAFE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        clr_faults = 1'b0, gate_reset = 1'b0;
    logic        safe_state, fault_n, pgood;

    int checks = 0, fails = 0, cyc = 0;

    typedef struct {
        int          at;
        int          sig;
        logic        val;
        string       tag;
    } item_t;
    item_t sb[$];
    item_t it;

    host_watchdog #(
        .CLK_HZ(1_000_000), .INTV0_US(40), .INTV1_US(80),
        .INTV2_US(160), .INTV3_US(320), .PULSE_US(56)
    ) u_host_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clr_faults(clr_faults), .gate_reset(gate_reset),
        .safe_state(safe_state), .fault_n(fault_n), .pgood(pgood)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops scoreboard items due at this cycle and compares
    always @(negedge clk) begin
        logic act;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            it = sb.pop_front();
            checks++;
            case (it.sig)
                S_FN:    act = fault_n;
                S_PG:    act = pgood;
                default: act = safe_state;
            endcase
            if (it.at < cyc) begin
                fails++;
                $display("FAIL %s: item for cycle %0d missed (now %0d)", it.tag, it.at, cyc);
            end else if (act !== it.val) begin
                fails++;
                $display("FAIL %s: cycle %0d sig %0d actual %b expected %b",
                         it.tag, cyc, it.sig, act, it.val);
            end
        end
    end

    task automatic push(input int at, input int sig, input logic val, input string tag);
        item_t n;
        n.at = at; n.sig = sig; n.val = val; n.tag = tag;
        sb.push_back(n);
    endtask

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d, output int acc);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        acc = cyc + 1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag,
                      output int acc);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        acc = cyc + 1;
        #1 check16(tag, bus_rdata, exp);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic strobe(input bit use_gate, output int acc);
        if (use_gate) gate_reset = 1'b1; else clr_faults = 1'b1;
        acc = cyc + 1;
        @(negedge clk);
        gate_reset = 1'b0; clr_faults = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        int w, k, c, t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        push(cyc, S_FN, 1'b1, "R1 fault_n");
        push(cyc, S_PG, 1'b1, "R1 pgood");
        push(cyc, S_SAFE, 1'b0, "R1 safe");
        rd(4'h9, 16'h0000, "R1 cfg", t);
        rd(4'h3, 16'h0000, "R1 status", t);

        // R4 R5 R6 R7: free-running expiry, code 0
        wr(4'h9, 16'h0008, w);
        push(w + L0 - 1, S_FN, 1'b1, "R4 before expiry");
        push(w + L0 - 1, S_PG, 1'b1, "R5 before pulse");
        push(w + L0, S_FN, 1'b0, "R4 fault_n at expiry");
        push(w + L0, S_PG, 1'b0, "R5 pulse start");
        push(w + L0, S_SAFE, 1'b1, "R4 safe at expiry");
        push(w + L0 + P - 1, S_PG, 1'b0, "R5 pulse last cycle");
        push(w + L0 + P, S_PG, 1'b1, "R5 pulse end");
        wait_to(w + L0 + P + 4);
        rd(4'h9, 16'h0000, "R6 enable cleared", t);
        rd(4'h3, 16'h0200, "R7 flag set", t);
        idle(100);
        push(cyc, S_FN, 1'b0, "R7 fault held");
        idle(1);
        strobe(1'b0, c);
        push(c, S_FN, 1'b1, "R8 clr releases fault_n");
        push(c, S_SAFE, 1'b0, "R8 clr releases safe");
        idle(1);
        rd(4'h3, 16'h0000, "R8 flag cleared", t);
        idle(200);
        push(cyc, S_FN, 1'b1, "R7 no refault without enable");
        idle(1);

        // R3 R9 R12: periodic restarts with decoy traffic, code 1
        wr(4'h9, 16'h0028, w);
        rd(4'h9, 16'h0028, "R2 cfg readback", t);
        k = w;
        for (int i = 0; i < 3; i++) begin
            wait_to(k + 55);
            rd(4'h3, 16'h0000, "R9 status read", t);
            wr(4'h5, 16'hFFFF, t);
            wr(4'h1, 16'h0000, t);
            rd(4'h1, 16'h0000, "R3 restart read", k);
        end
        push(k + 20, S_FN, 1'b1, "R3 alive after restarts");
        wait_to(k + 20);
        rd(4'h3, 16'h0000, "R9 decoy read", t);
        wr(4'h1, 16'h1234, t);
        wr(4'h7, 16'h0008, t);
        push(k + L1 - 1, S_FN, 1'b1, "R9 decoys do not restart");
        push(k + L1, S_FN, 1'b0, "R3 R12 expiry after last restart");
        wait_to(k + L1 + 3);
        strobe(1'b1, c);
        push(c, S_FN, 1'b1, "R8 gate_reset releases");
        wait_to(c + P + 2);

        // R10: restart read on the expiry edge, code 0
        wr(4'h9, 16'h0008, w);
        wait_to(w + L0 - 1);
        push(w + L0, S_FN, 1'b1, "R10 same-cycle restart");
        rd(4'h1, 16'h0000, "R10 read", k);
        push(k + L0 - 1, S_FN, 1'b1, "R10 before next expiry");
        push(k + L0, S_FN, 1'b0, "R10 expiry after restart");
        wait_to(k + L0 + 2);
        strobe(1'b0, c);
        wait_to(c + P + 2);

        // R8 priority: clear strobe on the expiry edge
        wr(4'h9, 16'h0008, w);
        wait_to(w + L0 - 1);
        strobe(1'b0, c);
        push(c, S_FN, 1'b0, "R8 expiry beats clear");
        push(c + 1, S_FN, 1'b0, "R8 fault stays");
        idle(3);
        strobe(1'b0, c);
        push(c, S_FN, 1'b1, "R8 later clear");
        wait_to(c + P + 2);

        // R11 R12: rewrite of enable does not restart, code 3
        wr(4'h9, 16'h0068, w);
        wait_to(w + 100);
        wr(4'h9, 16'h0068, t);
        push(w + L3 - 1, S_FN, 1'b1, "R11 before expiry");
        push(w + L3, S_FN, 1'b0, "R11 R12 expiry from first arm");
        wait_to(w + L3 + 2);
        rd(4'h9, 16'h0060, "R6 code kept, enable cleared", t);
        strobe(1'b1, c);
        wait_to(c + P + 2);

        // R2: disabled with a code set never expires
        wr(4'h9, 16'h0040, w);
        push(w + 400, S_FN, 1'b1, "R2 disabled stays quiet");
        wait_to(w + 401);
        rd(4'h9, 16'h0040, "R2 readback disabled", t);

        idle(5);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule